// File: doc/BRIEF.md
# GPIO Bank Register Block with Masked-Write Aliases

This block holds the control state for one bank of 32 general-purpose pins, organised as four ports of eight pins. Each pin has three control bits and one sampled input bit. The configuration bit hands the pin to the GPIO logic; when it is clear, an alternate function owns the pad. The output-enable bit selects the drive direction. The output-value bit is the level that is driven. The input bit is the pad level after a two-flop synchronizer.

Software reaches the registers over a simple 32-bit bus. Writes are taken on the clock edge, and reads are combinational on a separate read address. Each control register also appears at a second, aliased address 0x80 higher. A write to the alias carries a per-pin select mask in bits 15:8 and the new values in bits 7:0. One store can therefore change any subset of pins without a read-modify-write, and other agents sharing the port cannot be disturbed by it.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every configuration, output-enable and output-value bit is 0, so `pinOe` and `pinOut` are all zero and every register reads 0.
- R2: Register groups sit at byte offsets 0x00 (configuration), 0x10 (output enable), 0x20 (output value) and 0x30 (input). Port p of each group is at group offset + 4*p. Bit i of port p is pin 8*p+i.
- R3: A write to a direct address replaces all eight bits of that register with written bits 7:0. Written bits 31:8 are ignored.
- R4: A write to an alias address (direct address + 0x80, for the configuration, output-enable and output-value groups only) loads register bit i from written bit i for each i where written bit i+8 is 1. Bits whose mask bit is 0 keep their value.
- R5: Every read returns zeros in bits 31:8. A read of an alias address returns the underlying register.
- R6: `pinOe[n]` is 1 only when both the configuration bit and the output-enable bit of pin n are 1.
- R7: `pinOut[n]` follows the output-value bit of pin n.
- R8: A read of an input register returns `pinIn` as it was two rising clock edges earlier.
- R9: Writes to input registers, to the input alias range (0xB0 + 4*p), to misaligned addresses or to any unmapped address change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, taken on the rising edge |
| busWrAddr | input | 12 | Byte address of the write |
| busWrData | input | 32 | Write data (alias: mask in 15:8, values in 7:0) |
| busRdAddr | input | 12 | Byte address of the combinational read |
| busRdData | output | 32 | Read data |
| pinIn | input | 32 | Pad input levels, asynchronous |
| pinOut | output | 32 | Pad output levels |
| pinOe | output | 32 | Pad drive enables |

## Verification
Writes are tried with direct data that carries junk in the upper bits. This separates a true eight-bit replace from a write that leaks the upper bits. Alias writes are tried with partial, empty and full masks over non-trivial old values, which exposes a mask that is ignored, inverted or applied to the wrong half of the word. Writes aimed at input, unmapped, misaligned and out-of-range addresses are followed by read-back of the registers they might hit. Changes on `pinIn` are checked one and two edges later to pin down the synchronizer depth. Configuration and output-enable are set in mismatched combinations to show that the drive enable takes both bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_PINS = 8;

  typedef enum logic [1:0] {
    GRP_CFG = 2'd0,
    GRP_OE  = 2'd1,
    GRP_OUT = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  typedef struct packed {
    logic                 hit;
    logic                 isAlias;
    grp_e                 grp;
    logic [7:0]           port;
  } dec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    grp_e                 wrGrp;
    logic [7:0]           wrPort;
    logic [PORT_PINS-1:0] wrVal;
    logic [PORT_PINS-1:0] wrMask;
    logic                 rdHit;
    grp_e                 rdGrp;
    logic [7:0]           rdPort;
  } strb_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_PORTS  = 4,
  parameter int unsigned GRP_STRIDE = 16,
  parameter int unsigned ALIAS_OFS  = 128
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busWrAddr,
  input  logic [31:0]       busWrData,
  input  logic [ADDR_W-1:0] busRdAddr,
  output strb_t             strb
);
  localparam int unsigned NUM_GRP    = 4;
  localparam int unsigned ALIAS_SPAN = 3 * GRP_STRIDE;
  localparam int unsigned MAP_SPAN   = NUM_GRP * GRP_STRIDE;

  function automatic dec_t decodeAddr(input logic [ADDR_W-1:0] a);
    int unsigned ai, base;
    dec_t d;
    d  = '0;
    ai = 32'(a);
    if (ai >= ALIAS_OFS && ai < ALIAS_OFS + ALIAS_SPAN) begin
      d.isAlias = 1'b1;
      base      = ai - ALIAS_OFS;
    end else begin
      base      = ai;
    end
    if ((base % 4) == 0 && base < MAP_SPAN &&
        ((base % GRP_STRIDE) / 4) < NUM_PORTS) begin
      d.hit  = 1'b1;
      d.grp  = grp_e'(2'(base / GRP_STRIDE));
      d.port = 8'((base % GRP_STRIDE) / 4);
    end
    return d;
  endfunction

  dec_t wrDec, rdDec;
  logic unusedWrHigh;

  assign wrDec        = decodeAddr(busWrAddr);
  assign rdDec        = decodeAddr(busRdAddr);
  assign unusedWrHigh = ^busWrData[31:16];

  always_comb begin
    strb        = '0;
    strb.wrEn   = busWrEn && wrDec.hit && (wrDec.grp != GRP_IN);
    strb.wrGrp  = wrDec.grp;
    strb.wrPort = wrDec.port;
    strb.wrVal  = busWrData[PORT_PINS-1:0];
    strb.wrMask = wrDec.isAlias ? busWrData[2*PORT_PINS-1:PORT_PINS] : '1;
    strb.rdHit  = rdDec.hit;
    strb.rdGrp  = rdDec.grp;
    strb.rdPort = rdDec.port;
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int NPINS    = NUM_PORTS * PORT_PINS
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic [NPINS-1:0] inSync,
  output logic [31:0]      rdData,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe
);
  logic [NUM_PORTS-1:0][PORT_PINS-1:0] cfgR, oeR, outR;

  function automatic logic [PORT_PINS-1:0] merge(
    input logic [PORT_PINS-1:0] old, val, mask);
    return (old & ~mask) | (val & mask);
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    assign sel = strb.wrEn && (strb.wrPort == 8'(p));

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) cfgR[p] <= '0;
      else if (sel && strb.wrGrp == GRP_CFG)
        cfgR[p] <= merge(cfgR[p], strb.wrVal, strb.wrMask);

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) oeR[p] <= '0;
      else if (sel && strb.wrGrp == GRP_OE)
        oeR[p] <= merge(oeR[p], strb.wrVal, strb.wrMask);

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) outR[p] <= '0;
      else if (sel && strb.wrGrp == GRP_OUT)
        outR[p] <= merge(outR[p], strb.wrVal, strb.wrMask);

    assign pinOe[p*PORT_PINS +: PORT_PINS]  = cfgR[p] & oeR[p];
    assign pinOut[p*PORT_PINS +: PORT_PINS] = outR[p];
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strb.rdHit && strb.rdPort == 8'(p)) begin
        case (strb.rdGrp)
          GRP_CFG: rdData[PORT_PINS-1:0] = cfgR[p];
          GRP_OE:  rdData[PORT_PINS-1:0] = oeR[p];
          GRP_OUT: rdData[PORT_PINS-1:0] = outR[p];
          default: rdData[PORT_PINS-1:0] = inSync[p*PORT_PINS +: PORT_PINS];
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          NUM_PORTS   = 4,
  parameter int unsigned GRP_STRIDE  = 16,
  parameter int unsigned ALIAS_OFS   = 128,
  parameter int          SYNC_STAGES = 2,
  localparam int         NPINS       = NUM_PORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busWrAddr,
  input  logic [31:0]       busWrData,
  input  logic [ADDR_W-1:0] busRdAddr,
  output logic [31:0]       busRdData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe
);
  strb_t            strb;
  logic [NPINS-1:0] inSync;

  gpio_bank_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
    .GRP_STRIDE(GRP_STRIDE), .ALIAS_OFS(ALIAS_OFS)
  ) u_ctrl (
    .busWrEn(busWrEn), .busWrAddr(busWrAddr), .busWrData(busWrData),
    .busRdAddr(busRdAddr), .strb(strb)
  );

  gpio_bank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(inSync)
  );

  gpio_bank_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inSync(inSync),
    .rdData(busRdData), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int          ADDR_W     = 12,
  parameter int          NPINS      = 32,
  parameter int unsigned GRP_STRIDE = 16,
  parameter int unsigned ALIAS_OFS  = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busWrAddr,
  input logic [31:0]       busWrData,
  input logic [ADDR_W-1:0] busRdAddr,
  input logic [31:0]       busRdData,
  input logic [NPINS-1:0]  pinIn,
  input logic [NPINS-1:0]  pinOut,
  input logic [NPINS-1:0]  pinOe
);
  localparam logic [ADDR_W-1:0] CFG0   = '0;
  localparam logic [ADDR_W-1:0] OUT0   = ADDR_W'(2 * GRP_STRIDE);
  localparam logic [ADDR_W-1:0] IN0    = ADDR_W'(3 * GRP_STRIDE);
  localparam logic [ADDR_W-1:0] AOUT0  = ADDR_W'(ALIAS_OFS + 2 * GRP_STRIDE);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;

  // R3
  direct_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrAddr == OUT0) |=> pinOut[7:0] == $past(busWrData[7:0]));

  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrAddr == AOUT0) |=>
      ((pinOut[7:0] ^ $past(pinOut[7:0])) & ~$past(busWrData[15:8])) == 8'h00);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrAddr == AOUT0) |=>
      ((pinOut[7:0] ^ $past(busWrData[7:0])) & $past(busWrData[15:8])) == 8'h00);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(pinOut) && $stable(pinOe)));

  // R6
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrAddr == CFG0 && busWrData[7:0] == 8'h00) |=> pinOe[7:0] == 8'h00);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[31:8] == 24'h0);

  // R8
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && busRdAddr == IN0) |-> busRdData[7:0] == $past(pinIn[7:0], 2));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .ADDR_W(ADDR_W), .NPINS(NPINS), .GRP_STRIDE(GRP_STRIDE), .ALIAS_OFS(ALIAS_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrAddr(busWrAddr),
  .busWrData(busWrData), .busRdAddr(busRdAddr), .busRdData(busRdData),
  .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [11:0] busWrAddr = '0;
  logic [31:0] busWrData = '0;
  logic [11:0] busRdAddr = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrAddr(busWrAddr),
    .busWrData(busWrData), .busRdAddr(busRdAddr), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NVEC = 10;
  localparam logic [87:0] VEC [NVEC] = '{
    {12'h020, 32'hFFFF_FF5A, 12'h020, 32'h0000_005A}, // R3 upper junk dropped
    {12'h0A0, 32'h0000_0F03, 12'h0A0, 32'h0000_0053}, // R4 R5 partial mask
    {12'h0A0, 32'h0000_00FF, 12'h020, 32'h0000_0053}, // R4 empty mask
    {12'h094, 32'h0000_8181, 12'h014, 32'h0000_0081}, // R4 R2 oe port 1
    {12'h00C, 32'h0000_00A5, 12'h08C, 32'h0000_00A5}, // R2 R5 cfg port 3
    {12'h030, 32'h0000_00FF, 12'h030, 32'h0000_0000}, // R9 input read-only
    {12'h100, 32'h0000_00FF, 12'h020, 32'h0000_0053}, // R9 out of range
    {12'h022, 32'h0000_00FF, 12'h020, 32'h0000_0053}, // R9 misaligned
    {12'h0B0, 32'h0000_FFFF, 12'h0B0, 32'h0000_0000}, // R9 input alias
    {12'h028, 32'h0000_003C, 12'h028, 32'h0000_003C}  // R2 out port 2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busWrAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    busRdAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pinOut", pinOut, 32'h0);
    check("R1 pinOe", pinOe, 32'h0);
    readCheck("R1 cfg read", 12'h000, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck("R1 out read", 12'h02C, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][87:76], VEC[i][75:44]);
      readCheck($sformatf("table row %0d (R2..R5,R9)", i), VEC[i][43:32], VEC[i][31:0]);
    end

    // R7 pad outputs follow output registers
    check("R7 port0", {24'h0, pinOut[7:0]}, 32'h53);
    check("R7 port2", {24'h0, pinOut[23:16]}, 32'h3C);

    // R6 drive enable needs both bits
    busWrite(12'h000, 32'h0F);
    busWrite(12'h010, 32'hFF);
    check("R6 port0 partial cfg", {24'h0, pinOe[7:0]}, 32'h0F);
    check("R6 port1 oe without cfg", {24'h0, pinOe[15:8]}, 32'h00);
    busWrite(12'h084, 32'h0000_0101);
    check("R6 port1 one cfg bit", {24'h0, pinOe[15:8]}, 32'h01);
    check("R6 port3 cfg without oe", {24'h0, pinOe[31:24]}, 32'h00);

    // R4 full mask over alias of cfg
    busWrite(12'h080, 32'h0000_FFC3);
    readCheck("R4 full mask", 12'h000, 32'hC3);

    // R8 two-edge synchronizer
    @(negedge clk);
    pinIn = 32'hDEAD_BEEF;
    @(negedge clk);
    readCheck("R8 one edge", 12'h030, 32'h00);
    @(negedge clk);
    readCheck("R8 two edges p0", 12'h030, 32'hEF);
    readCheck("R8 two edges p3", 12'h03C, 32'hDE);
    readCheck("R9 unmapped read", 12'h040, 32'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule